// File: doc/BRIEF.md
# Drawing Command Queue with Thermometer Status

This block sits between a host register port and a 2D drawing engine. The host writes 16-bit command and parameter words into an eight-entry first-in first-out queue. The engine takes words from the head of the queue through a valid/pop handshake whenever it is ready. A single register-select input chooses between two host registers. With the select low, writes go into the queue and reads return the status word. With the select high, the access reaches the configuration register, whose bit 0 turns the accelerator register group on or off.

The status word reports queue occupancy as a thermometer code in its low byte, so the host can test for free space with a single mask. The word also carries the engine-busy, pixel-data-ready, queue-empty and overflow flags. While the accelerator is disabled, the status word reads as all ones and queue writes are ignored. The queue contents are kept, and the engine can still drain them.

Queue control is a three-state machine. The states are Q_EMPTY (no words held), Q_PART (one to seven words held) and Q_FULL (eight words held). A push, a pop or both at once change the count, and each clock edge moves the machine to the state that the new count selects. The transitions are: empty-to-part on a push; part-to-part on a push and pop together, or on a push or pop that stays inside 1..7; part-to-full on the eighth push; full-to-part on a pop; part-to-empty on the last pop. Every other combination holds the state.

Top module: `draw_cmd_queue`

## Requirements
- R1: After reset the queue is empty, the enable flag is 0, `eng_valid` is 0, the status word (select 0) reads 0xFFFF and the configuration register (select 1) reads 0x0000.
- R2: While enable is 0, the status word reads 0xFFFF and writes with select 0 leave the queue unchanged. Words already queued are preserved.
- R3: A write with select 1 sets enable to `host_wdata[0]`. The configuration register reads back enable in bit 0 and zeros in bits 15..1.
- R4: While enabled, status bits 7..0 equal (2^n)-1 for a queue holding n words: 0x00 is empty, 0x01 is one word, 0xFF is full.
- R5: Status bit 10 is 1 exactly when the queue holds no words.
- R6: `eng_valid` is high whenever the queue holds a word. `eng_word` presents the oldest word, and the engine receives the words in the order they were written.
- R7: A select-0 write while enabled and full is dropped and sets the sticky overflow flag, status bit 11. The next select-1 write clears that flag.
- R8: A push and a pop in the same cycle leave the word count unchanged.
- R9: Status bit 9 shows `eng_busy` and bit 8 shows `pix_ready`, each as sampled at the previous clock edge. Both flags read 0 after reset.
- R10: While enabled, status bits 15..12 read 0.
- R11: The occupancy code changes on the same clock edge that completes a push or a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per word |
| host_sel | input | 1 | Register select: 0 queue/status, 1 configuration |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register |
| eng_valid | output | 1 | Queue head holds a word |
| eng_word | output | 16 | Oldest queued word |
| eng_pop | input | 1 | Engine takes the head word |
| eng_busy | input | 1 | Engine is executing a command |
| pix_ready | input | 1 | Read-back pixel data waits for the host |

## Verification
On every cycle, the assertions check several structural properties. The occupancy byte is always a contiguous thermometer. The count never passes the queue depth. The controller state agrees with the count, and `eng_valid` follows the count. A push and a pop together hold the count steady. Disabled writes never change the count. The bench scenarios cover the behaviour that depends on a sequence of events: the order of words seen by the engine, the exact status values after each push, the sticky overflow flag and how it clears, the one-cycle delay on the busy and pixel flags, and the preservation of queued words across a disable.

// File: rtl/draw_cmd_queue_pkg.sv
package draw_cmd_queue_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_t;

    localparam int STAT_W     = 16;
    localparam int BIT_PIX    = 8;
    localparam int BIT_BUSY   = 9;
    localparam int BIT_EMPTY  = 10;
    localparam int BIT_OVF    = 11;
endpackage

// File: rtl/dcq_storage.sv
module dcq_storage #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/dcq_ctrl.sv
module dcq_ctrl
    import draw_cmd_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             cfg_wr,
    input  logic             cfg_en_bit,
    input  logic             eng_pop,
    output logic             push_en,
    output logic             pop_en,
    output logic [CNT_W-1:0] count,
    output logic             enable,
    output logic             ovf,
    output logic             is_empty,
    output logic             is_full
);
    q_state_t         state, state_nx;
    logic [CNT_W-1:0] count_nx;

    assign push_en = cmd_wr && enable && !is_full;
    assign pop_en  = eng_pop && !is_empty;

    always_comb begin
        unique case ({push_en, pop_en})
            2'b10:   count_nx = count + 1'b1;
            2'b01:   count_nx = count - 1'b1;
            default: count_nx = count;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: if (push_en) state_nx = Q_PART;
            Q_PART: begin
                if (count_nx == CNT_W'(DEPTH)) state_nx = Q_FULL;
                else if (count_nx == '0)       state_nx = Q_EMPTY;
            end
            Q_FULL:  if (pop_en) state_nx = Q_PART;
            default: state_nx = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            ovf    <= 1'b0;
        end else if (cfg_wr) begin
            enable <= cfg_en_bit;
            ovf    <= 1'b0;
        end else if (cmd_wr && enable && is_full) begin
            ovf    <= 1'b1;
        end
    end

    always_comb begin
        is_empty = (state == Q_EMPTY);
        is_full  = (state == Q_FULL);
    end

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r5_state_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY) == (count == '0));
    a_r8_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> $stable(count));
    a_r2_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !eng_pop) |=> $stable(count));
    a_r7_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && enable && is_full && !cfg_wr) |=> ovf);
endmodule

// File: rtl/dcq_status.sv
module dcq_status
    import draw_cmd_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  count,
    input  logic              enable,
    input  logic              ovf,
    input  logic              busy_q,
    input  logic              pix_q,
    output logic [STAT_W-1:0] status
);
    logic [DEPTH-1:0] therm;

    for (genvar i = 0; i < DEPTH; i++) begin : g_therm
        assign therm[i] = (count > CNT_W'(i));
    end

    always_comb begin
        status = '0;
        status[DEPTH-1:0] = therm;
        status[BIT_PIX]   = pix_q;
        status[BIT_BUSY]  = busy_q;
        status[BIT_EMPTY] = (count == '0);
        status[BIT_OVF]   = ovf;
        if (!enable) status = '1;
    end

    always_comb begin
        if (enable) begin
            a_r4_therm_contig: assert (((therm + 1'b1) & therm) == '0);
            a_r10_high_zero: assert (status[STAT_W-1:12] == '0);
        end
    end
endmodule

// File: rtl/draw_cmd_queue.sv
module draw_cmd_queue
    import draw_cmd_queue_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              eng_valid,
    output logic [WORD_W-1:0] eng_word,
    input  logic              eng_pop,
    input  logic              eng_busy,
    input  logic              pix_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             cmd_wr, cfg_wr;
    logic             push_en, pop_en;
    logic [CNT_W-1:0] count;
    logic             enable, ovf, is_empty, is_full;
    logic             busy_q, pix_q;
    logic [STAT_W-1:0] status;

    assign cmd_wr = host_wr && !host_sel;
    assign cfg_wr = host_wr && host_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pix_q  <= 1'b0;
        end else begin
            busy_q <= eng_busy;
            pix_q  <= pix_ready;
        end
    end

    dcq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cfg_wr(cfg_wr),
        .cfg_en_bit(host_wdata[0]), .eng_pop(eng_pop),
        .push_en(push_en), .pop_en(pop_en), .count(count),
        .enable(enable), .ovf(ovf), .is_empty(is_empty), .is_full(is_full)
    );

    dcq_storage #(.DEPTH(DEPTH), .WORD_W(WORD_W)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push_en), .pop(pop_en),
        .wdata(host_wdata), .head(eng_word)
    );

    dcq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) stat_i (
        .count(count), .enable(enable), .ovf(ovf),
        .busy_q(busy_q), .pix_q(pix_q), .status(status)
    );

    assign eng_valid  = !is_empty;
    assign host_rdata = host_sel ? {{(WORD_W-1){1'b0}}, enable} : WORD_W'(status);

    a_r6_valid_follows_count: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid == (count != '0));
    a_r9_busy_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> busy_q);
    a_r2_disabled_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !host_sel) |-> (host_rdata == '1));
endmodule

// File: tb/draw_cmd_queue_tb_top.sv
module draw_cmd_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        eng_valid;
    logic [15:0] eng_word;
    logic        eng_pop = 1'b0;
    logic        eng_busy = 1'b0;
    logic        pix_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    draw_cmd_queue dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_valid(eng_valid), .eng_word(eng_word), .eng_pop(eng_pop),
        .eng_busy(eng_busy), .pix_ready(pix_ready)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0;
        #1;
    endtask

    task automatic read_reg(input logic sel, output logic [15:0] d);
        host_sel = sel; #1; d = host_rdata; host_sel = 1'b0; #1;
    endtask

    task automatic pop_check(input string req, input logic [15:0] exp);
        check(req, {15'b0, eng_valid}, 16'h0001);
        check(req, eng_word, exp);
        @(negedge clk); eng_pop = 1'b1;
        @(negedge clk); eng_pop = 1'b0; #1;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        read_reg(1'b0, d); check("R1 status", d, 16'hFFFF);
        read_reg(1'b1, d); check("R1 config", d, 16'h0000);
        check("R1 valid", {15'b0, eng_valid}, 16'h0000);
    endtask

    task automatic t_disabled_write;
        logic [15:0] d;
        write_reg(1'b0, 16'hDEAD);
        read_reg(1'b0, d); check("R2 disabled status", d, 16'hFFFF);
        check("R2 disabled push ignored", {15'b0, eng_valid}, 16'h0000);
    endtask

    task automatic t_enable;
        logic [15:0] d;
        write_reg(1'b1, 16'hFFFF);
        read_reg(1'b1, d); check("R3 config readback", d, 16'h0001);
        read_reg(1'b0, d); check("R5 empty flag / R10", d, 16'h0400);
    endtask

    task automatic t_fill;
        logic [15:0] d;
        for (int n = 1; n <= 8; n++) begin
            write_reg(1'b0, 16'h1000 + 16'(n));
            read_reg(1'b0, d);
            check($sformatf("R4 R11 therm n=%0d", n), d, 16'((1 << n) - 1));
        end
    endtask

    task automatic t_overflow;
        logic [15:0] d;
        write_reg(1'b0, 16'hBEEF);
        read_reg(1'b0, d); check("R7 overflow sticky", d, 16'h08FF);
        @(negedge clk); #1;
        read_reg(1'b0, d); check("R7 overflow holds", d, 16'h08FF);
        write_reg(1'b1, 16'h0001);
        read_reg(1'b0, d); check("R7 cleared by config write", d, 16'h00FF);
    endtask

    task automatic t_drain;
        logic [15:0] d;
        for (int n = 1; n <= 8; n++) begin
            pop_check($sformatf("R6 order word %0d", n), 16'h1000 + 16'(n));
            read_reg(1'b0, d);
            check($sformatf("R4 R11 after pop %0d", n), d,
                  (n == 8) ? 16'h0400 : 16'((1 << (8 - n)) - 1));
        end
        check("R6 valid low when empty", {15'b0, eng_valid}, 16'h0000);
    endtask

    task automatic t_simul;
        logic [15:0] d;
        write_reg(1'b0, 16'hA001);
        write_reg(1'b0, 16'hA002);
        write_reg(1'b0, 16'hA003);
        @(negedge clk);
        host_sel = 1'b0; host_wdata = 16'hA004; host_wr = 1'b1; eng_pop = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_pop = 1'b0; #1;
        read_reg(1'b0, d); check("R8 push+pop count", d, 16'h0007);
        pop_check("R8 R6 order after simul", 16'hA002);
    endtask

    task automatic t_disable_keep;
        logic [15:0] d;
        write_reg(1'b1, 16'h0000);
        read_reg(1'b0, d); check("R2 disabled with data", d, 16'hFFFF);
        write_reg(1'b0, 16'h5555);
        write_reg(1'b1, 16'h0001);
        read_reg(1'b0, d); check("R2 queue preserved", d, 16'h0003);
        pop_check("R2 R6 kept word 1", 16'hA003);
        pop_check("R2 R6 kept word 2", 16'hA004);
        check("R2 write while disabled dropped", {15'b0, eng_valid}, 16'h0000);
    endtask

    task automatic t_flags;
        logic [15:0] d;
        @(negedge clk); eng_busy = 1'b1;
        #1; read_reg(1'b0, d); check("R9 busy not yet", d, 16'h0400);
        @(negedge clk); #1;
        read_reg(1'b0, d); check("R9 busy shown", d, 16'h0600);
        eng_busy = 1'b0; pix_ready = 1'b1;
        @(negedge clk); #1;
        read_reg(1'b0, d); check("R9 pixel ready shown", d, 16'h0500);
        pix_ready = 1'b0;
        @(negedge clk); #1;
        read_reg(1'b0, d); check("R9 flags cleared", d, 16'h0400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_disabled_write();
        t_enable();
        t_fill();
        t_overflow();
        t_drain();
        t_simul();
        t_disable_keep();
        t_flags();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule